// File: doc/BRIEF.md
# Register Usage Scoreboard with Hazard Stall

This block sits at the issue stage of a small in-order pipeline. Each cycle the decoder offers one instruction with two source register indices, one destination index and an operation code. The scoreboard says whether the instruction may issue now, or whether it must be held because of a read-after-write, write-after-read or write-after-write conflict with instructions that are still executing. The upstream stage holds a refused instruction on its inputs. Because issue is in program order, every younger instruction waits behind it.

Nine architectural registers (indices 0 to 8) are tracked. Each register has a reader counter and a single pending-write flag. An issued instruction adds one to the reader count of each distinct source register and sets the flag of its destination. An internal latency model then releases the same resources. Add and subtract release two cycles after issue, and multiply releases one cycle later. With single issue and these latencies, no instruction ever completes before an older one. Two releases can land on the same clock edge, and a release can share an edge with a new issue. The reader counters, the write flags and the in-flight count are brought out as ports.

Top module: `reg_scoreboard`

## Requirements
- R1: After a synchronous active-high reset, every reader counter is 0, every pending-write flag is 0 and the in-flight count is 0.
- R2: `issue_go` is high in a cycle exactly when `req_valid` is high and no stall flag is high. The bookkeeping of an issued instruction is visible on the state ports from the next cycle on.
- R3: `stall_raw` is high when `req_valid` is high and either source register has its pending-write flag set. No stall flag is high while `req_valid` is low.
- R4: `stall_war` is high when `req_valid` is high and the destination register has a nonzero reader count.
- R5: `stall_waw` is high when `req_valid` is high and the destination register already has its pending-write flag set, so at most one in-flight writer exists per register.
- R6: Reading a register that other in-flight instructions are reading causes no stall, and the reader count accumulates one per such instruction.
- R7: An add or subtract issued in cycle t releases on the clock edge that ends cycle t+2. From cycle t+3 its source counts are one lower and its destination flag is clear.
- R8: A multiply issued in cycle t releases on the edge that ends cycle t+3, which is one cycle later than an add.
- R9: When a release and an issue touch the same register on one edge, or when two releases do, the counter changes by the number of increments minus the number of decrements.
- R10: Operation code 2 is multiply. Codes 0 (add), 1 (subtract) and 3 all use the add latency.
- R11: `inflight` equals the number of issued, unreleased instructions. `stall_full` refuses issue when that count equals MAX_INFLIGHT (default 15), so no reader counter can overflow.
- R12: An instruction that names the same register in both source fields raises that register's reader count by one, not two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A decoded instruction is offered for issue |
| req_op | input | 2 | Operation code: 0 add, 1 subtract, 2 multiply, 3 add latency |
| req_src_a | input | 4 | First source register index (0 to 8) |
| req_src_b | input | 4 | Second source register index (0 to 8) |
| req_dst | input | 4 | Destination register index (0 to 8) |
| issue_go | output | 1 | Offered instruction issues this cycle |
| stall_raw | output | 1 | Source waits on a pending write |
| stall_war | output | 1 | Destination still has readers |
| stall_waw | output | 1 | Destination already has a pending writer |
| stall_full | output | 1 | In-flight limit reached |
| wr_pend | output | 9 | Pending-write flag per register, bit i for register i |
| rd_cnt_flat | output | 36 | Reader counts, register i at bits [4i+3:4i] |
| inflight | output | 4 | Number of issued, unreleased instructions |

## Verification
The bench holds a dependent instruction on the inputs until the reference model allows it. A scoreboard that freed a register one cycle early or late would then issue in the wrong cycle, or report counts that do not match. The bench issues a multiply and then an add on the next cycle, so both release on one edge. It also issues a new reader of a register on the edge where an older reader releases it. A design that applied only one update per edge would show a count that is off by one. Instructions that repeat a source register, and idle cycles whose fields would conflict if they were valid, check that counters do not double and that stalls appear only for valid requests.

// File: rtl/sb_pkg.sv
package sb_pkg;
    localparam int NUM_REGS = 9;
    localparam int IDX_W    = 4;
    localparam int ADD_LAT  = 2;
    localparam int MUL_LAT  = ADD_LAT + 1;

    typedef logic [IDX_W-1:0]    ridx_t;
    typedef logic [NUM_REGS-1:0] rmask_t;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_MUL = 2'd2,
        OP_RSV = 2'd3
    } op_e;

    typedef struct packed {
        logic  vld;
        ridx_t src_a;
        ridx_t src_b;
        ridx_t dst;
    } uop_t;

    function automatic rmask_t reg_sel(input ridx_t idx);
        rmask_t v;
        v = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (idx == ridx_t'(i)) v[i] = 1'b1;
        end
        return v;
    endfunction

    function automatic rmask_t src_mask(input uop_t u);
        return u.vld ? (reg_sel(u.src_a) | reg_sel(u.src_b)) : '0;
    endfunction

    function automatic rmask_t dst_mask(input uop_t u);
        return u.vld ? reg_sel(u.dst) : '0;
    endfunction
endpackage

// File: rtl/sb_release_line.sv
module sb_release_line
    import sb_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  uop_t push,
    output uop_t rel
);
    uop_t stage_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH - 1; i++) stage_q[i] <= stage_q[i+1];
            stage_q[DEPTH-1] <= push;
        end
    end

    assign rel = stage_q[0];
endmodule

// File: rtl/sb_hazard.sv
module sb_hazard
    import sb_pkg::*;
(
    input  uop_t   req,
    input  rmask_t wr_pend,
    input  rmask_t rd_busy,
    input  logic   at_cap,
    output logic   raw,
    output logic   war,
    output logic   waw,
    output logic   full
);
    rmask_t s_m, d_m;

    always_comb begin
        s_m  = src_mask(req);
        d_m  = dst_mask(req);
        raw  = |(s_m & wr_pend);
        war  = |(d_m & rd_busy);
        waw  = |(d_m & wr_pend);
        full = req.vld & at_cap;
    end
endmodule

// File: rtl/sb_reg_table.sv
module sb_reg_table
    import sb_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  rmask_t                    inc,
    input  rmask_t                    dec_a,
    input  rmask_t                    dec_b,
    input  rmask_t                    set_w,
    input  rmask_t                    clr_w,
    output logic [NUM_REGS*CNT_W-1:0] cnt_flat,
    output rmask_t                    rd_busy,
    output rmask_t                    wr_pend
);
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        logic [CNT_W-1:0] cnt_q;
        logic [CNT_W-1:0] cnt_d;
        logic             wr_q;

        always_comb begin
            cnt_d = cnt_q + CNT_W'(inc[r]) - CNT_W'(dec_a[r]) - CNT_W'(dec_b[r]);
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q <= '0;
                wr_q  <= 1'b0;
            end else begin
                cnt_q <= cnt_d;
                if (set_w[r])      wr_q <= 1'b1;
                else if (clr_w[r]) wr_q <= 1'b0;
            end
        end

        assign cnt_flat[r*CNT_W +: CNT_W] = cnt_q;
        assign rd_busy[r] = (cnt_q != '0);
        assign wr_pend[r] = wr_q;

        // R11: a counter at its ceiling never takes an unbalanced increment
        p_no_overflow_r11: assert property (@(posedge clk) disable iff (rst)
            (cnt_q == '1) |-> !(inc[r] && !dec_a[r] && !dec_b[r]));
        // R9: releases never remove more readers than are recorded
        p_no_underflow_r9: assert property (@(posedge clk) disable iff (rst)
            ($countones({dec_a[r], dec_b[r]}) <= int'(cnt_q) + int'(inc[r])));
        // R5: a second writer is never recorded on a pending register
        p_single_writer_r5: assert property (@(posedge clk) disable iff (rst)
            set_w[r] |-> !wr_q);
        // R7: a release only clears a write that is actually pending
        p_clear_owned_r7: assert property (@(posedge clk) disable iff (rst)
            clr_w[r] |-> wr_q);
    end
endmodule

// File: rtl/reg_scoreboard.sv
module reg_scoreboard
    import sb_pkg::*;
#(
    parameter int CNT_W        = 4,
    parameter int MAX_INFLIGHT = 15,
    localparam int IF_W        = $clog2(MAX_INFLIGHT + 1)
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              req_valid,
    input  logic [1:0]                        req_op,
    input  logic [IDX_W-1:0]                  req_src_a,
    input  logic [IDX_W-1:0]                  req_src_b,
    input  logic [IDX_W-1:0]                  req_dst,
    output logic                              issue_go,
    output logic                              stall_raw,
    output logic                              stall_war,
    output logic                              stall_waw,
    output logic                              stall_full,
    output logic [NUM_REGS-1:0]               wr_pend,
    output logic [NUM_REGS*CNT_W-1:0]         rd_cnt_flat,
    output logic [IF_W-1:0]                   inflight
);
    uop_t   req_u, push_add, push_mul, rel_add, rel_mul;
    logic   is_mul, at_cap;
    rmask_t rd_busy, inc_m, dec_a_m, dec_b_m, set_m, clr_m;
    logic [IF_W-1:0] inflight_q;

    always_comb begin
        req_u  = '{vld: req_valid, src_a: req_src_a, src_b: req_src_b, dst: req_dst};
        is_mul = (op_e'(req_op) == OP_MUL);
        at_cap = (inflight_q >= IF_W'(MAX_INFLIGHT));
    end

    sb_hazard u_hazard (
        .req     (req_u),
        .wr_pend (wr_pend),
        .rd_busy (rd_busy),
        .at_cap  (at_cap),
        .raw     (stall_raw),
        .war     (stall_war),
        .waw     (stall_waw),
        .full    (stall_full)
    );

    assign issue_go = req_valid & ~(stall_raw | stall_war | stall_waw | stall_full);

    always_comb begin
        push_add = (issue_go && !is_mul) ? req_u : '0;
        push_mul = (issue_go &&  is_mul) ? req_u : '0;
        inc_m    = issue_go ? src_mask(req_u) : '0;
        set_m    = issue_go ? dst_mask(req_u) : '0;
        dec_a_m  = src_mask(rel_add);
        dec_b_m  = src_mask(rel_mul);
        clr_m    = dst_mask(rel_add) | dst_mask(rel_mul);
    end

    sb_release_line #(.DEPTH(ADD_LAT)) u_add_line (
        .clk (clk), .rst (rst), .push (push_add), .rel (rel_add)
    );

    sb_release_line #(.DEPTH(MUL_LAT)) u_mul_line (
        .clk (clk), .rst (rst), .push (push_mul), .rel (rel_mul)
    );

    sb_reg_table #(.CNT_W(CNT_W)) u_table (
        .clk      (clk),
        .rst      (rst),
        .inc      (inc_m),
        .dec_a    (dec_a_m),
        .dec_b    (dec_b_m),
        .set_w    (set_m),
        .clr_w    (clr_m),
        .cnt_flat (rd_cnt_flat),
        .rd_busy  (rd_busy),
        .wr_pend  (wr_pend)
    );

    always_ff @(posedge clk) begin
        if (rst) inflight_q <= '0;
        else     inflight_q <= inflight_q + IF_W'(issue_go)
                               - IF_W'(rel_add.vld) - IF_W'(rel_mul.vld);
    end

    assign inflight = inflight_q;

    // R11: the in-flight count never passes its limit
    p_inflight_cap_r11: assert property (@(posedge clk) disable iff (rst)
        inflight_q <= IF_W'(MAX_INFLIGHT));

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_chk
        // R7: add/sub holds its destination two cycles, clear in the third
        p_add_hold_r7: assert property (@(posedge clk) disable iff (rst)
            (issue_go && !is_mul && req_dst == ridx_t'(r))
            |=> wr_pend[r] ##1 wr_pend[r] ##1 !wr_pend[r]);
        // R8: multiply holds its destination one cycle longer
        p_mul_hold_r8: assert property (@(posedge clk) disable iff (rst)
            (issue_go && is_mul && req_dst == ridx_t'(r))
            |=> wr_pend[r] ##1 wr_pend[r] ##1 wr_pend[r] ##1 !wr_pend[r]);
    end
endmodule

// File: tb/tb_reg_scoreboard.sv
module tb_reg_scoreboard;
    import sb_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic       req_valid = 1'b0;
    logic [1:0] req_op    = 2'd0;
    logic [3:0] req_src_a = 4'd0, req_src_b = 4'd0, req_dst = 4'd0;
    logic       issue_go, stall_raw, stall_war, stall_waw, stall_full;
    logic [8:0] wr_pend;
    logic [35:0] rd_cnt_flat;
    logic [3:0] inflight;

    reg_scoreboard dut (
        .clk (clk), .rst (rst), .req_valid (req_valid), .req_op (req_op),
        .req_src_a (req_src_a), .req_src_b (req_src_b), .req_dst (req_dst),
        .issue_go (issue_go), .stall_raw (stall_raw), .stall_war (stall_war),
        .stall_waw (stall_waw), .stall_full (stall_full), .wr_pend (wr_pend),
        .rd_cnt_flat (rd_cnt_flat), .inflight (inflight)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // reference model
    int m_cnt [9];
    bit m_wr  [9];
    int m_cyc = 0;
    int q_rel [$];
    int q_a   [$];
    int q_b   [$];
    int q_d   [$];

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d (model cycle %0d)",
                     tag, what, act, exp, m_cyc);
        end
    endtask

    task automatic step(input bit v, input int op, input int a, input int b,
                        input int d, input string tag, output bit went);
        bit e_raw, e_war, e_waw, e_full, e_go;
        @(negedge clk);
        req_valid = v;
        req_op    = op[1:0];
        req_src_a = a[3:0];
        req_src_b = b[3:0];
        req_dst   = d[3:0];
        #1;
        e_raw  = v && (m_wr[a] || m_wr[b]);
        e_war  = v && (m_cnt[d] != 0);
        e_waw  = v && m_wr[d];
        e_full = v && (q_rel.size() >= 15);
        e_go   = v && !(e_raw || e_war || e_waw || e_full);
        chk(issue_go  == e_go,   tag, "issue_go",   int'(issue_go),  int'(e_go));
        chk(stall_raw == e_raw,  tag, "stall_raw",  int'(stall_raw), int'(e_raw));
        chk(stall_war == e_war,  tag, "stall_war",  int'(stall_war), int'(e_war));
        chk(stall_waw == e_waw,  tag, "stall_waw",  int'(stall_waw), int'(e_waw));
        chk(stall_full == e_full, tag, "stall_full", int'(stall_full), int'(e_full));
        for (int r = 0; r < 9; r++) begin
            chk(int'(rd_cnt_flat[r*4 +: 4]) == m_cnt[r], tag, $sformatf("rd_cnt[%0d]", r),
                int'(rd_cnt_flat[r*4 +: 4]), m_cnt[r]);
            chk(wr_pend[r] == m_wr[r], tag, $sformatf("wr_pend[%0d]", r),
                int'(wr_pend[r]), int'(m_wr[r]));
        end
        chk(int'(inflight) == q_rel.size(), tag, "inflight", int'(inflight), q_rel.size());
        @(posedge clk);
        for (int i = q_rel.size() - 1; i >= 0; i--) begin
            if (q_rel[i] == m_cyc) begin
                m_cnt[q_a[i]]--;
                if (q_b[i] != q_a[i]) m_cnt[q_b[i]]--;
                m_wr[q_d[i]] = 0;
                q_rel.delete(i); q_a.delete(i); q_b.delete(i); q_d.delete(i);
            end
        end
        if (e_go) begin
            q_rel.push_back(m_cyc + ((op == 2) ? 3 : 2));
            q_a.push_back(a); q_b.push_back(b); q_d.push_back(d);
            m_cnt[a]++;
            if (b != a) m_cnt[b]++;
            m_wr[d] = 1;
        end
        m_cyc++;
        went = e_go;
    endtask

    task automatic idle(input int n, input string tag);
        bit w;
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, tag, w);
    endtask

    task automatic hold(input int op, input int a, input int b, input int d,
                        input string tag);
        bit w;
        w = 0;
        for (int i = 0; i < 8 && !w; i++) step(1, op, a, b, d, tag, w);
        chk(w, tag, "held instruction eventually issued", int'(w), 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        bit w;
        for (int r = 0; r < 9; r++) begin m_cnt[r] = 0; m_wr[r] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        idle(2, "R1");
        // R2 plain issue, R7 add release timing
        step(1, 0, 2, 3, 1, "R2", w);
        idle(4, "R7");
        // R3 read-after-write, plus idle request with conflicting fields
        step(1, 0, 2, 3, 1, "R3", w);
        hold(0, 1, 5, 4, "R3");
        step(0, 0, 4, 4, 6, "R3", w);
        idle(4, "R3");
        // R4 write-after-read against a multiply, R8 multiply latency
        step(1, 2, 6, 7, 5, "R8", w);
        hold(0, 0, 0, 6, "R4");
        idle(5, "R8");
        // R5 write-after-write, subtract as second writer
        step(1, 0, 0, 0, 2, "R5", w);
        hold(1, 3, 3, 2, "R5");
        idle(4, "R5");
        // R12 duplicate source, R6 shared readers
        step(1, 0, 8, 8, 0, "R12", w);
        step(1, 0, 8, 2, 1, "R6", w);
        step(1, 2, 4, 8, 3, "R6", w);
        idle(5, "R6");
        // R9 release and issue of the same reader on one edge
        step(1, 0, 4, 0, 1, "R9", w);
        idle(1, "R9");
        step(1, 0, 4, 0, 2, "R9", w);
        idle(4, "R9");
        // R9 two releases on one edge sharing sources
        step(1, 2, 5, 6, 7, "R9", w);
        step(1, 0, 5, 6, 3, "R9", w);
        idle(5, "R9");
        // R10 codes 1 and 3 take the add latency
        step(1, 1, 0, 1, 6, "R10", w);
        idle(1, "R10");
        step(1, 3, 2, 3, 7, "R10", w);
        idle(4, "R10");
        // R11 in-flight count under back-to-back issue
        step(1, 2, 0, 1, 2, "R11", w);
        step(1, 0, 3, 4, 5, "R11", w);
        step(1, 0, 6, 7, 8, "R11", w);
        idle(5, "R11");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule